// File: doc/BRIEF.md
# Core Supply Dynamic Voltage Step Controller

This block is the digital side of a core supply regulator whose output is set by a 4-bit code. It picks one of two target codes. The sleep code is used while the host enable pin is low and sleep selection is on. The active code is used in every other case. The block then walks the regulator DAC code toward that target, one code per fixed number of clock cycles. When the DAC code reaches a newly chosen target, it raises a "voltage available" flag. The flag stays set until the host reads it.

The code-to-voltage map has three ranges. Codes 0 to 4 run from 1.00 V to 1.20 V in 50 mV steps. Codes 5 to 14 run from 1.22 V to 1.40 V in 20 mV steps. Code 15 gives 1.45 V. The block moves only codes and has no knowledge of volts.

A comparator reports when the supply output is low, and the block turns that input into a sticky fault flag that clears on read. The comparator is ignored for a blanking time after any target change or host-enable edge, so a falling enable never raises the fault by itself. An optional mask stops monitoring while the host enable is low. The step period and the blanking length are parameters.

Top module: `corev_dvs_ctrl`

## Requirements
- R1: While reset is held and just after it is released, dac_code is 0111 (1.26 V), avail is 0 and fault is 0.
- R2: The target is slp_code when host_en is 0 and slp_en is 1, and act_code otherwise. With slp_en at 0, a low host_en leaves the active code in force.
- R3: dac_code changes by at most one code per clock. Count the clock edge that samples a new target as edge 1. The first step lands on edge STEP_CYCLES+1, and each later step follows STEP_CYCLES edges after the one before it.
- R4: After a target change over a distance of d codes, in either direction, avail becomes 1 at clock edge d*STEP_CYCLES+2, counted as in R3. At that point dac_code equals the target.
- R5: avail stays 1 until a cycle with rd_stb high, and is 0 after that cycle.
- R6: A target change during a ramp clears avail at the next edge. The next step is taken from the current dac_code toward the new target.
- R7: When monitoring is active, vlow_in at 1 sets fault at the next edge. fault stays 1 until a cycle with rd_stb high, and is 0 after that cycle.
- R8: vlow_in is ignored on the edge of a target change or host_en edge, and on the BLANK_CYCLES edges that follow it. In particular, a falling host_en never sets fault.
- R9: With host_en at 0, mon_mask_slp at 1 suppresses monitoring. With mon_mask_slp at 0, monitoring continues in sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_code | input | 4 | Target code for active mode |
| slp_code | input | 4 | Target code for sleep mode |
| slp_en | input | 1 | 1: apply slp_code while host_en is low |
| mon_mask_slp | input | 1 | 1: no supply monitoring while host_en is low |
| host_en | input | 1 | Host enable; low means sleep |
| vlow_in | input | 1 | Comparator: supply output below expected |
| rd_stb | input | 1 | Host status read; clears avail and fault |
| dac_code | output | 4 | Code driven to the regulator DAC |
| avail | output | 1 | Sticky: DAC code reached the new target |
| fault | output | 1 | Sticky: supply low seen while monitored |

## Verification
The ramp is driven in several ways: an upward change, a downward change of a different length, a redirect to a nearby code partway through a ramp, and target changes caused only by host_en with sleep selection on and off. The cycle count to avail separates the correct step pacing from off-by-one pacing, and the direction cases separate a two-way ramp from a one-way one. Comparator pulses are placed just inside and just outside the blanking window after target changes and after an enable fall. They are applied with the sleep mask set and cleared. This shows that the window length is exact and that the mask gates only the sleep state.

// File: rtl/dvs_pkg.sv
// Shared types for the core supply step controller.
// Assumes a 4-bit regulator code whose reset value is the 1.26 V point.
package dvs_pkg;
    localparam int unsigned CODE_W = 4;
    typedef logic [CODE_W-1:0] code_t;
    localparam code_t CODE_RST = code_t'(7);
    typedef enum logic [1:0] {DIR_HOLD = 2'd0, DIR_UP = 2'd1, DIR_DOWN = 2'd2} dir_e;
endpackage

// File: rtl/dvs_target_sel.sv
// Picks the active or sleep target and registers it with the host enable.
// Flags a target change and a host enable edge by comparing the current
// selection with the registered copy. Inputs are assumed synchronous.
module dvs_target_sel
    import dvs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  code_t act_code,
    input  code_t slp_code,
    input  logic  slp_en,
    input  logic  host_en,
    output code_t tgt_q,
    output logic  host_q,
    output logic  tgt_chg,
    output logic  en_edge
);
    code_t tgt_now;

    // Select the sleep code only when enable is low and sleep selection is on
    always_comb tgt_now = (!host_en && slp_en) ? slp_code : act_code;

    // Register target and enable for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q  <= CODE_RST;
            host_q <= 1'b1;
        end else begin
            tgt_q  <= tgt_now;
            host_q <= host_en;
        end
    end

    assign tgt_chg = (tgt_now != tgt_q);
    assign en_edge = (host_en != host_q);

    // R2
    sleep_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_en && slp_en) |=> (tgt_q == $past(slp_code)));
    // R2
    active_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en || !slp_en) |=> (tgt_q == $past(act_code)));
endmodule

// File: rtl/dvs_ramp.sv
// Walks the DAC code one step per STEP_CYCLES clocks toward the target and
// keeps the read-to-clear "target reached" flag. A target change restarts
// the step timer and clears the flag.
module dvs_ramp
    import dvs_pkg::*;
#(
    parameter int unsigned STEP_CYCLES = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  code_t tgt_q,
    input  logic  tgt_chg,
    input  logic  rd_stb,
    output code_t dac,
    output logic  avail
);
    localparam int unsigned CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(STEP_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             pend;
    dir_e             dir;

    // Direction from the present code to the registered target
    always_comb begin
        if (dac < tgt_q)      dir = DIR_UP;
        else if (dac > tgt_q) dir = DIR_DOWN;
        else                  dir = DIR_HOLD;
    end

    // Step timer and DAC code update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac <= CODE_RST;
            cnt <= '0;
        end else if (tgt_chg || dir == DIR_HOLD) begin
            cnt <= '0;
        end else if (cnt == STEP_LAST) begin
            cnt <= '0;
            dac <= (dir == DIR_UP) ? dac + 1'b1 : dac - 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Reached flag: armed by a change, set on arrival, cleared by read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            avail <= 1'b0;
        end else if (tgt_chg) begin
            pend  <= 1'b1;
            avail <= 1'b0;
        end else if (pend && dir == DIR_HOLD) begin
            pend  <= 1'b0;
            avail <= 1'b1;
        end else if (rd_stb) begin
            avail <= 1'b0;
        end
    end

    // R3
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((int'(dac) - int'($past(dac)) <= 1) && (int'($past(dac)) - int'(dac) <= 1)));
    // R4
    reached_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avail) |-> (dac == tgt_q));
    // R6
    redirect_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_chg |=> !avail);
    // R5
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !pend) |=> !avail);
endmodule

// File: rtl/dvs_fault_mon.sv
// Turns the supply-low comparator into a sticky, read-to-clear fault flag.
// The comparator is blanked for BLANK_CYCLES after each target change or
// host enable edge, and optionally while the host enable is low.
module dvs_fault_mon #(
    parameter int unsigned BLANK_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgt_chg,
    input  logic en_edge,
    input  logic host_en,
    input  logic host_q,
    input  logic mask_slp,
    input  logic vlow_in,
    input  logic rd_stb,
    output logic fault
);
    localparam int unsigned BW = (BLANK_CYCLES > 0) ? $clog2(BLANK_CYCLES + 1) : 1;
    localparam logic [BW-1:0] BLANK_LD = BW'(BLANK_CYCLES);

    logic [BW-1:0] blank_cnt;
    logic          trig;
    logic          watch;

    assign trig = tgt_chg | en_edge;

    // Blanking timer, reloaded on every trigger
    always_ff @(posedge clk) begin
        if (!rst_n)              blank_cnt <= BLANK_LD;
        else if (trig)           blank_cnt <= BLANK_LD;
        else if (blank_cnt != 0) blank_cnt <= blank_cnt - 1'b1;
    end

    // Monitoring is live outside the window and outside masked sleep
    always_comb watch = (blank_cnt == '0) && !trig && !(mask_slp && !host_q);

    // Sticky fault flag, set wins over read
    always_ff @(posedge clk) begin
        if (!rst_n)                fault <= 1'b0;
        else if (watch && vlow_in) fault <= 1'b1;
        else if (rd_stb)           fault <= 1'b0;
    end

    // R8
    blank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_cnt != '0 && !fault) |=> !fault);
    // R8
    en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(host_en) && !fault) |=> !fault);
    // R9
    sleep_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_slp && !host_q && !fault) |=> !fault);
    // R7
    fault_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !vlow_in) |=> !fault);
endmodule

// File: rtl/corev_dvs_ctrl.sv
// Core supply step controller top: target selection, code ramp with
// reached flag, and blanked supply fault monitor.
// Assumes all inputs are synchronous to clk.
module corev_dvs_ctrl
    import dvs_pkg::*;
#(
    parameter int unsigned STEP_CYCLES  = 4,
    parameter int unsigned BLANK_CYCLES = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] act_code,
    input  logic [3:0] slp_code,
    input  logic       slp_en,
    input  logic       mon_mask_slp,
    input  logic       host_en,
    input  logic       vlow_in,
    input  logic       rd_stb,
    output logic [3:0] dac_code,
    output logic       avail,
    output logic       fault
);
    code_t tgt_q;
    logic  host_q;
    logic  tgt_chg;
    logic  en_edge;

    dvs_target_sel u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_code (act_code),
        .slp_code (slp_code),
        .slp_en   (slp_en),
        .host_en  (host_en),
        .tgt_q    (tgt_q),
        .host_q   (host_q),
        .tgt_chg  (tgt_chg),
        .en_edge  (en_edge)
    );

    dvs_ramp #(.STEP_CYCLES(STEP_CYCLES)) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tgt_q   (tgt_q),
        .tgt_chg (tgt_chg),
        .rd_stb  (rd_stb),
        .dac     (dac_code),
        .avail   (avail)
    );

    dvs_fault_mon #(.BLANK_CYCLES(BLANK_CYCLES)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt_chg  (tgt_chg),
        .en_edge  (en_edge),
        .host_en  (host_en),
        .host_q   (host_q),
        .mask_slp (mon_mask_slp),
        .vlow_in  (vlow_in),
        .rd_stb   (rd_stb),
        .fault    (fault)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (dac_code == 4'd7 && !avail && !fault));
endmodule

// File: tb/tb_corev_dvs_ctrl.sv
`timescale 1ns/1ps
module tb_corev_dvs_ctrl;
    localparam int STEP  = 4;
    localparam int BLANK = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] act_code = 4'd7;
    logic [3:0] slp_code = 4'd7;
    logic       slp_en = 1'b1;
    logic       mon_mask_slp = 1'b0;
    logic       host_en = 1'b1;
    logic       vlow_in = 1'b0;
    logic       rd_stb = 1'b0;
    logic [3:0] dac_code;
    logic       avail;
    logic       fault;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    corev_dvs_ctrl #(.STEP_CYCLES(STEP), .BLANK_CYCLES(BLANK)) dut (
        .clk(clk), .rst_n(rst_n), .act_code(act_code), .slp_code(slp_code),
        .slp_en(slp_en), .mon_mask_slp(mon_mask_slp), .host_en(host_en),
        .vlow_in(vlow_in), .rd_stb(rd_stb), .dac_code(dac_code),
        .avail(avail), .fault(fault)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Count sampled cycles from the edge that takes a new target until avail
    task automatic wait_avail(input int limit, output int n);
        n = 0;
        do begin
            @(posedge clk); @(negedge clk);
            n++;
        end while (!avail && n < limit);
    endtask

    task automatic read_pulse();
        rd_stb = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic t_reset();
        cycles(4);
        chk("R1 dac during reset", dac_code, 7);
        rst_n = 1'b1;
        cycles(1);
        chk("R1 dac after reset", dac_code, 7);
        chk("R1 avail after reset", avail, 0);
        chk("R1 fault after reset", fault, 0);
        cycles(BLANK + 2);
    endtask

    task automatic t_ramp_up();
        int n;
        act_code = 4'd12;
        wait_avail(200, n);
        chk("R4 up ramp cycles", n, 5 * STEP + 2);
        chk("R4 up ramp dac", dac_code, 12);
        cycles(3);
        chk("R5 avail held until read", avail, 1);
        read_pulse();
        chk("R5 avail cleared by read", avail, 0);
    endtask

    task automatic t_ramp_down();
        int n;
        act_code = 4'd2;
        wait_avail(200, n);
        chk("R4 down ramp cycles", n, 10 * STEP + 2);
        chk("R4 down ramp dac", dac_code, 2);
    endtask

    task automatic t_redirect();
        int n;
        act_code = 4'd9;
        cycles(2 * STEP + 3);
        chk("R3 pacing after two steps", dac_code, 4);
        chk("R6 avail low mid ramp", avail, 0);
        act_code = 4'd3;
        wait_avail(200, n);
        chk("R6 redirect cycles", n, 1 * STEP + 2);
        chk("R6 redirect dac", dac_code, 3);
        read_pulse();
    endtask

    task automatic t_sleep_select();
        int n;
        slp_code = 4'd5;
        cycles(3);
        chk("R2 sleep code ignored while enabled", dac_code, 3);
        host_en = 1'b0;
        wait_avail(200, n);
        chk("R2 sleep target cycles", n, 2 * STEP + 2);
        chk("R2 sleep target dac", dac_code, 5);
        host_en = 1'b1;
        wait_avail(200, n);
        chk("R2 back to active cycles", n, 2 * STEP + 2);
        chk("R2 back to active dac", dac_code, 3);
        read_pulse();
    endtask

    task automatic t_sleep_disabled();
        slp_en = 1'b0;
        host_en = 1'b0;
        cycles(5 * STEP);
        chk("R2 sleep selection off keeps active code", dac_code, 3);
        chk("R2 no change means avail stays clear", avail, 0);
        host_en = 1'b1;
        slp_en = 1'b1;
        cycles(BLANK + 2);
    endtask

    task automatic t_fault_basic();
        vlow_in = 1'b1;
        cycles(1);
        vlow_in = 1'b0;
        chk("R7 fault set by comparator", fault, 1);
        cycles(4);
        chk("R7 fault sticky", fault, 1);
        read_pulse();
        chk("R7 fault cleared by read", fault, 0);
    endtask

    task automatic t_blank_target();
        act_code = 4'd6;
        vlow_in = 1'b1;
        repeat (BLANK + 1) @(posedge clk);
        @(negedge clk);
        vlow_in = 1'b0;
        cycles(1);
        chk("R8 blanked after target change", fault, 0);
        vlow_in = 1'b1;
        cycles(1);
        vlow_in = 1'b0;
        chk("R8 monitoring resumes after window", fault, 1);
        read_pulse();
        cycles(4 * STEP);
    endtask

    task automatic t_blank_enfall();
        host_en = 1'b0;
        vlow_in = 1'b1;
        repeat (BLANK + 1) @(posedge clk);
        @(negedge clk);
        vlow_in = 1'b0;
        cycles(1);
        chk("R8 enable fall does not set fault", fault, 0);
        vlow_in = 1'b1;
        cycles(1);
        vlow_in = 1'b0;
        chk("R9 unmasked sleep still monitored", fault, 1);
        read_pulse();
        chk("R7 read clears in sleep", fault, 0);
        mon_mask_slp = 1'b1;
        vlow_in = 1'b1;
        cycles(3);
        vlow_in = 1'b0;
        cycles(1);
        chk("R9 masked sleep ignores comparator", fault, 0);
        host_en = 1'b1;
        cycles(BLANK + 2);
        vlow_in = 1'b1;
        cycles(1);
        vlow_in = 1'b0;
        chk("R9 mask has no effect when awake", fault, 1);
        read_pulse();
        mon_mask_slp = 1'b0;
    endtask

    initial begin
        t_reset();
        t_ramp_up();
        t_ramp_down();
        t_redirect();
        t_sleep_select();
        t_sleep_disabled();
        t_fault_basic();
        t_blank_target();
        t_blank_enfall();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule